// File: doc/BRIEF.md
# Mode-Switched Serial Pin Interface for a Radio Transceiver

This block owns the three serial pins a radio transceiver shares with its host controller: a clock line, a data line that normally runs host-to-device, and a data line that runs device-to-host. The operating mode decides what each pin does. In configuration mode the block is a serial slave for register traffic. In transmit mode the host's encoded data arrives on the forward data line. In receive mode the block either becomes the bus master and clocks received bytes out, or sends the raw demodulated stream straight out on the forward line. In standby all three pins float.

An active-low select input detaches the block from the shared bus. While it is high, every pin floats and the power-amplifier enable is held off. A configuration byte that was only partly transferred is discarded. All other state, including a master transfer in flight, is kept until the select returns. The mode and data-management inputs are sampled into an internal mode register only between bytes, so a byte is never cut in half by a mode change. Each pin is presented as a drive-enable and a drive-value pair. Pad cells outside the block build the real bidirectional pins.

Top module: `xcvr_serial_if`

## Requirements
- R1: While `sel_n` is 1, `sclk_oe`, `mosi_oe`, `miso_oe` and `pa_en` are all 0. Any partly received configuration byte is discarded, so no `cfg_rx_valid` follows from its bits.
- R2: While `sel_n` is 1, an unfinished master transfer is frozen. After `sel_n` returns to 0 it resumes and delivers the whole byte unchanged.
- R3: In configuration mode (`mode_i` = 2'b00, `sel_n` = 0), the block samples `mosi_in` on each falling edge of `sclk_in`, most significant bit first. After the eighth falling edge it presents the byte on `cfg_rx_byte` with a one-cycle `cfg_rx_valid` pulse.
- R4: In configuration mode `miso_oe` is 1 and the other two enables are 0. `cfg_tx_byte` is captured at the first rising `sclk_in` edge of a byte and sent on `miso_out` most significant bit first. Each bit changes on a rising edge and is stable at the following falling edge.
- R5: In transmit mode (`mode_i` = 2'b01, `sel_n` = 0), no pin is driven, `tx_bit` follows `mosi_in`, and `pa_en` is 1.
- R6: In receive mode with data management (`mode_i` = 2'b10, `dm_en_i` = 1), `sclk_oe` and `mosi_oe` are 1 and `miso_oe` is 0. Each byte goes out MSB first on `mosi_out`, with the bit stable while `sclk_out` is high. `sclk_out` stays high and low for `CLK_DIV` system cycles each. `byte_sent` pulses for one cycle after the eighth falling edge.
- R7: Bytes enter through a one-deep holding register. `rx_ready` is 0 while it is full. A byte that is waiting starts right after the previous one, with no byte lost.
- R8: In data-managed receive mode with nothing to send, `sclk_out` and `mosi_out` are both 0 while driven.
- R9: In receive mode without data management (`dm_en_i` = 0), `mosi_oe` is 1 with `mosi_out` equal to `rx_raw`, and `sclk_oe` and `miso_oe` are 0.
- R10: In standby (`mode_i` = 2'b11), no pin is driven and `pa_en` is 0. Standby is also the state after reset.
- R11: A change on `mode_i` or `dm_en_i` takes effect only when no configuration byte is partly received and no master byte is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Bus select, high detaches all pins |
| mode_i | input | 2 | Requested mode: 00 config, 01 transmit, 10 receive, 11 standby |
| dm_en_i | input | 1 | Data management enable for receive mode |
| sclk_in | input | 1 | Clock pin input value |
| mosi_in | input | 1 | Forward data pin input value |
| sclk_oe | output | 1 | Clock pin drive enable |
| sclk_out | output | 1 | Clock pin drive value |
| mosi_oe | output | 1 | Forward data pin drive enable |
| mosi_out | output | 1 | Forward data pin drive value |
| miso_oe | output | 1 | Return data pin drive enable |
| miso_out | output | 1 | Return data pin drive value |
| cfg_rx_byte | output | WORD_W | Last byte written by the host |
| cfg_rx_valid | output | 1 | One-cycle pulse when cfg_rx_byte is new |
| cfg_tx_byte | input | WORD_W | Register read data to return to the host |
| tx_bit | output | 1 | Encoded transmit data from the host |
| pa_en | output | 1 | Power amplifier enable |
| rx_byte | input | WORD_W | Received byte to send as master |
| rx_byte_valid | input | 1 | Load rx_byte into the holding register |
| rx_ready | output | 1 | Holding register empty |
| byte_sent | output | 1 | One-cycle pulse at the end of a master byte |
| rx_raw | input | 1 | Raw demodulated receive stream |

## Verification
The bench aims at the cases where pin roles and byte framing meet. It cuts a configuration byte after four bits by raising the select. A design that kept those bits would report a shifted byte or an extra valid pulse. It freezes a master byte halfway through. A design that reset or kept shifting during the detach would deliver a corrupted byte or a stray clock edge. It requests a mode change in the middle of a master byte. A design that switched at once would take its drivers off the pins mid-byte. It also fills the holding register while the shifter is busy. A design with a faulty ready flag would drop or repeat the second byte.

// File: rtl/xsi_pkg.sv
// Package: shared mode encoding for the serial pin interface.
// Assumes the mode input uses exactly these 2-bit codes.
package xsi_pkg;
    typedef enum logic [1:0] {
        MODE_CFG  = 2'b00,
        MODE_TX   = 2'b01,
        MODE_RX   = 2'b10,
        MODE_STBY = 2'b11
    } xsi_mode_e;
endpackage

// File: rtl/xsi_slave.sv
// Configuration-mode serial slave. It synchronises the host clock and data
// pins, shifts data in on falling edges, and shifts read data out on rising
// edges (clock idles low, data launched on rising edges).
// Assumes the host clock half-period is several system cycles longer than
// SYNC_STAGES. While active_i is low the bit counter is cleared, which drops
// any partial byte.
module xsi_slave #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              sclk_in,
    input  logic              mosi_in,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              miso_bit_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    output logic              mid_byte_o
);
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [SYNC_STAGES:0]   s_pipe;
    logic [SYNC_STAGES-1:0] m_pipe;
    logic [CW-1:0]          cnt;
    logic [WORD_W-1:0]      rx_sh;
    logic [WORD_W-1:0]      tx_sh;
    logic                   s_rise, s_fall, m_now;

    assign s_rise     = s_pipe[SYNC_STAGES-1] & ~s_pipe[SYNC_STAGES];
    assign s_fall     = ~s_pipe[SYNC_STAGES-1] & s_pipe[SYNC_STAGES];
    assign m_now      = m_pipe[SYNC_STAGES-1];
    assign miso_bit_o = tx_sh[WORD_W-1];
    assign mid_byte_o = (cnt != '0);

    // Synchronise the host clock and data pins into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_pipe <= '0;
            m_pipe <= '0;
        end else begin
            s_pipe <= {s_pipe[SYNC_STAGES-1:0], sclk_in};
            m_pipe <= {m_pipe[SYNC_STAGES-2:0], mosi_in};
        end
    end

    // Shift read data out on rising edges and write data in on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rx_word_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (!active_i) begin
                cnt <= '0;
            end else begin
                if (s_rise) begin
                    if (cnt == '0) tx_sh <= tx_word_i;
                    else           tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                end
                if (s_fall) begin
                    rx_sh <= {rx_sh[WORD_W-2:0], m_now};
                    if (cnt == CW'(WORD_W-1)) begin
                        cnt        <= '0;
                        rx_word_o  <= {rx_sh[WORD_W-2:0], m_now};
                        rx_valid_o <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/xsi_master.sv
// Receive-mode serial master. It holds one byte in a holding register, moves
// it into a shifter when idle, and clocks it out MSB first. Each half of the
// serial clock lasts CLK_DIV system cycles. The data bit is set while the
// clock is low and held through the high phase.
// Assumes run_i low freezes all transfer state; loads are accepted any time.
module xsi_master #(
    parameter int WORD_W  = 8,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [WORD_W-1:0] load_word_i,
    input  logic              load_i,
    output logic              ready_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              sent_o
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] hold, shreg;
    logic              hold_full, busy, phase;
    logic [DW-1:0]     divcnt;
    logic [CW-1:0]     bitcnt;

    assign ready_o = ~hold_full;
    assign busy_o  = busy;
    assign sclk_o  = busy & phase;
    assign mosi_o  = busy & shreg[WORD_W-1];

    // Fill the holding register and run the divider-paced shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
            shreg     <= '0;
            busy      <= 1'b0;
            phase     <= 1'b0;
            divcnt    <= '0;
            bitcnt    <= '0;
            sent_o    <= 1'b0;
        end else begin
            sent_o <= 1'b0;
            if (load_i && !hold_full) begin
                hold      <= load_word_i;
                hold_full <= 1'b1;
            end
            if (run_i) begin
                if (!busy) begin
                    if (hold_full) begin
                        shreg     <= hold;
                        hold_full <= 1'b0;
                        busy      <= 1'b1;
                        phase     <= 1'b0;
                        divcnt    <= '0;
                        bitcnt    <= '0;
                    end
                end else if (divcnt == DW'(CLK_DIV-1)) begin
                    divcnt <= '0;
                    if (!phase) begin
                        phase <= 1'b1;
                    end else begin
                        phase <= 1'b0;
                        if (bitcnt == CW'(WORD_W-1)) begin
                            busy   <= 1'b0;
                            sent_o <= 1'b1;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            shreg  <= {shreg[WORD_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    divcnt <= divcnt + 1'b1;
                end
            end
        end
    end

    // R6
    sent_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sent_o |-> $past(busy));
    // R7
    start_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(hold_full));
endmodule

// File: rtl/xsi_pinmux.sv
// Pin role selector. From the latched mode and the select input it decides
// which pins are driven, what they carry, and whether the amplifier may run.
// Assumes every drive value is forced to 0 while its enable is off.
module xsi_pinmux
    import xsi_pkg::*;
(
    input  logic      sel_n,
    input  xsi_mode_e mode_i,
    input  logic      dm_i,
    input  logic      slave_miso_i,
    input  logic      m_sclk_i,
    input  logic      m_mosi_i,
    input  logic      rx_raw_i,
    input  logic      mosi_in,
    output logic      sclk_oe,
    output logic      sclk_out,
    output logic      mosi_oe,
    output logic      mosi_out,
    output logic      miso_oe,
    output logic      miso_out,
    output logic      tx_bit,
    output logic      pa_en
);
    // Route pins according to the current mode; everything floats when detached.
    always_comb begin
        sclk_oe  = 1'b0;
        sclk_out = 1'b0;
        mosi_oe  = 1'b0;
        mosi_out = 1'b0;
        miso_oe  = 1'b0;
        miso_out = 1'b0;
        tx_bit   = 1'b0;
        pa_en    = 1'b0;
        if (!sel_n) begin
            unique case (mode_i)
                MODE_CFG: begin
                    miso_oe  = 1'b1;
                    miso_out = slave_miso_i;
                end
                MODE_TX: begin
                    tx_bit = mosi_in;
                    pa_en  = 1'b1;
                end
                MODE_RX: begin
                    mosi_oe = 1'b1;
                    if (dm_i) begin
                        sclk_oe  = 1'b1;
                        sclk_out = m_sclk_i;
                        mosi_out = m_mosi_i;
                    end else begin
                        mosi_out = rx_raw_i;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xcvr_serial_if.sv
// Top of the transceiver serial pin interface. It latches the requested mode
// between bytes and ties together the configuration slave, the receive
// master and the pin selector.
// Assumes the mode and data-management inputs are synchronous to clk.
module xcvr_serial_if
    import xsi_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int CLK_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [1:0]        mode_i,
    input  logic              dm_en_i,
    input  logic              sclk_in,
    input  logic              mosi_in,
    output logic              sclk_oe,
    output logic              sclk_out,
    output logic              mosi_oe,
    output logic              mosi_out,
    output logic              miso_oe,
    output logic              miso_out,
    output logic [WORD_W-1:0] cfg_rx_byte,
    output logic              cfg_rx_valid,
    input  logic [WORD_W-1:0] cfg_tx_byte,
    output logic              tx_bit,
    output logic              pa_en,
    input  logic [WORD_W-1:0] rx_byte,
    input  logic              rx_byte_valid,
    output logic              rx_ready,
    output logic              byte_sent,
    input  logic              rx_raw
);
    xsi_mode_e cur_mode;
    logic      cur_dm;
    logic      s_mid, m_busy, s_miso, m_sclk, m_mosi;
    logic      cfg_active, m_run;

    assign cfg_active = !sel_n && (cur_mode == MODE_CFG);
    assign m_run      = !sel_n && (cur_mode == MODE_RX) && cur_dm;

    // Take a new mode only when no byte is in progress in either direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mode <= MODE_STBY;
            cur_dm   <= 1'b0;
        end else if (!s_mid && !m_busy) begin
            cur_mode <= xsi_mode_e'(mode_i);
            cur_dm   <= dm_en_i;
        end
    end

    xsi_slave #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) i_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (cfg_active),
        .sclk_in    (sclk_in),
        .mosi_in    (mosi_in),
        .tx_word_i  (cfg_tx_byte),
        .miso_bit_o (s_miso),
        .rx_word_o  (cfg_rx_byte),
        .rx_valid_o (cfg_rx_valid),
        .mid_byte_o (s_mid)
    );

    xsi_master #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) i_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (m_run),
        .load_word_i (rx_byte),
        .load_i      (rx_byte_valid),
        .ready_o     (rx_ready),
        .sclk_o      (m_sclk),
        .mosi_o      (m_mosi),
        .busy_o      (m_busy),
        .sent_o      (byte_sent)
    );

    xsi_pinmux i_pinmux (
        .sel_n        (sel_n),
        .mode_i       (cur_mode),
        .dm_i         (cur_dm),
        .slave_miso_i (s_miso),
        .m_sclk_i     (m_sclk),
        .m_mosi_i     (m_mosi),
        .rx_raw_i     (rx_raw),
        .mosi_in      (mosi_in),
        .sclk_oe      (sclk_oe),
        .sclk_out     (sclk_out),
        .mosi_oe      (mosi_oe),
        .mosi_out     (mosi_out),
        .miso_oe      (miso_oe),
        .miso_out     (miso_out),
        .tx_bit       (tx_bit),
        .pa_en        (pa_en)
    );

    // R1
    sel_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !(sclk_oe || mosi_oe || miso_oe || pa_en));
    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_busy && $past(m_busy)) |-> $stable(cur_mode));
endmodule

// File: tb/test_xcvr_serial_if.sv
`timescale 1ns/1ps
module test_xcvr_serial_if;
    localparam int W = 8;
    localparam int HALF = 10;

    logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b0;
    logic [1:0] mode_i = 2'b11;
    logic dm_en_i = 1'b0, sclk_in = 1'b0, mosi_in = 1'b0;
    logic sclk_oe, sclk_out, mosi_oe, mosi_out, miso_oe, miso_out;
    logic [W-1:0] cfg_rx_byte, cfg_tx_byte = '0, rx_byte = '0;
    logic cfg_rx_valid, tx_bit, pa_en, rx_byte_valid = 1'b0, rx_ready, byte_sent, rx_raw = 1'b0;

    int checks = 0, errors = 0, sent_cnt = 0, m_total = 0;
    logic [W-1:0] cfg_q[$];
    logic [W-1:0] mst_q[$];
    logic [W-1:0] m_acc = '0;
    int m_bits = 0;
    logic m_prev = 1'b0;

    always #2.5 clk = ~clk;

    xcvr_serial_if i_xcvr_serial_if (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .mode_i(mode_i), .dm_en_i(dm_en_i),
        .sclk_in(sclk_in), .mosi_in(mosi_in), .sclk_oe(sclk_oe), .sclk_out(sclk_out),
        .mosi_oe(mosi_oe), .mosi_out(mosi_out), .miso_oe(miso_oe), .miso_out(miso_out),
        .cfg_rx_byte(cfg_rx_byte), .cfg_rx_valid(cfg_rx_valid), .cfg_tx_byte(cfg_tx_byte),
        .tx_bit(tx_bit), .pa_en(pa_en), .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid),
        .rx_ready(rx_ready), .byte_sent(byte_sent), .rx_raw(rx_raw)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Host transfer: launch on rising, let the device sample at falling; nbits may cut a byte short.
    task automatic host_xfer(input logic [W-1:0] wr, input logic [W-1:0] rd_exp, input int nbits);
        logic [W-1:0] rd = '0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sclk_in = 1'b1;
            mosi_in = wr[W-1-i];
            idle(HALF);
            rd = {rd[W-2:0], miso_out};
            sclk_in = 1'b0;
            idle(HALF);
        end
        if (nbits == W) begin
            chk("R4 miso byte", rd, rd_exp);
            chk("R4 miso_oe", miso_oe, 1);
        end
    endtask

    // Driver: queue the expected byte and hand it to the holding register.
    task automatic push_master(input logic [W-1:0] b);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_byte = b;
        rx_byte_valid = 1'b1;
        mst_q.push_back(b);
        m_total++;
        @(negedge clk);
        rx_byte_valid = 1'b0;
    endtask

    // Monitor: pop expected bytes as configuration writes and master bytes appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_rx_valid) begin
                if (cfg_q.size() == 0) chk("R3/R1 unexpected cfg byte", cfg_rx_byte, 0 - 1);
                else chk("R3 cfg byte", cfg_rx_byte, cfg_q.pop_front());
            end
            if (byte_sent) sent_cnt++;
            if (sclk_oe) begin
                if (sclk_out && !m_prev) begin
                    m_acc = {m_acc[W-2:0], mosi_out};
                    m_bits++;
                    if (m_bits == W) begin
                        m_bits = 0;
                        if (mst_q.size() == 0) chk("R6 unexpected master byte", m_acc, 0 - 1);
                        else chk("R6 master byte", m_acc, mst_q.pop_front());
                    end
                end
                m_prev = sclk_out;
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(3);
        // R10 reset state is standby
        chk("R10 sclk_oe", sclk_oe, 0);
        chk("R10 mosi_oe", mosi_oe, 0);
        chk("R10 miso_oe", miso_oe, 0);
        chk("R10 pa_en", pa_en, 0);
        chk("R7 ready after reset", rx_ready, 1);

        // R3 R4 configuration writes and reads
        mode_i = 2'b00;
        idle(3);
        cfg_tx_byte = 8'h3C; cfg_q.push_back(8'hA5);
        host_xfer(8'hA5, 8'h3C, W);
        cfg_tx_byte = 8'hE1; cfg_q.push_back(8'h81);
        host_xfer(8'h81, 8'hE1, W);
        chk("R4 sclk_oe cfg", sclk_oe, 0);
        chk("R4 mosi_oe cfg", mosi_oe, 0);

        // R1 partial byte dropped on detach
        host_xfer(8'hF0, 8'h00, 4);
        sel_n = 1'b1;
        idle(3);
        chk("R1 miso_oe detached", miso_oe, 0);
        chk("R1 sclk_oe detached", sclk_oe, 0);
        sel_n = 1'b0;
        idle(3);
        cfg_tx_byte = 8'h42; cfg_q.push_back(8'h5A);
        host_xfer(8'h5A, 8'h42, W);
        idle(5);
        chk("R3 cfg queue drained", cfg_q.size(), 0);

        // R5 transmit
        mode_i = 2'b01;
        idle(3);
        mosi_in = 1'b1; idle(1);
        chk("R5 tx_bit high", tx_bit, 1);
        mosi_in = 1'b0; idle(1);
        chk("R5 tx_bit low", tx_bit, 0);
        chk("R5 pa_en", pa_en, 1);
        chk("R5 no drive", {sclk_oe, mosi_oe, miso_oe}, 0);
        sel_n = 1'b1; idle(1);
        chk("R1 pa_en off when detached", pa_en, 0);
        sel_n = 1'b0;

        // R9 raw receive
        mode_i = 2'b10; dm_en_i = 1'b0;
        idle(3);
        rx_raw = 1'b1; idle(1);
        chk("R9 raw high", mosi_out, 1);
        rx_raw = 1'b0; idle(1);
        chk("R9 raw low", mosi_out, 0);
        chk("R9 enables", {sclk_oe, mosi_oe, miso_oe}, 3'b010);

        // R8 data-managed receive idle
        dm_en_i = 1'b1;
        idle(3);
        chk("R8 enables", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
        chk("R8 idle lines low", {sclk_out, mosi_out}, 0);

        // R6 R7 back-to-back bytes through the holding register
        push_master(8'hC3);
        push_master(8'h96);
        idle(1);
        chk("R7 ready low while holding", rx_ready, 0);
        while (mst_q.size() != 0) idle(1);
        idle(2 * 4 + 4);

        // R2 freeze mid-byte
        push_master(8'h6E);
        idle(30);
        sel_n = 1'b1;
        idle(40);
        chk("R2 detached no drive", {sclk_oe, mosi_oe}, 0);
        sel_n = 1'b0;
        while (mst_q.size() != 0) idle(1);
        idle(12);

        // R11 mode change requested mid-byte
        push_master(8'hB4);
        idle(20);
        mode_i = 2'b00;
        idle(4);
        chk("R11 still master mid-byte", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
        while (mst_q.size() != 0) idle(1);
        idle(12);
        chk("R11 switched after byte", {sclk_oe, mosi_oe, miso_oe}, 3'b001);
        chk("R6 byte_sent count", sent_cnt, m_total);

        // R10 standby
        mode_i = 2'b11;
        idle(3);
        chk("R10 standby no drive", {sclk_oe, mosi_oe, miso_oe, pa_en}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule